// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block is the control logic behind a two-sided open-drain data line. One side faces the host and the other faces the card. Both lines rest high through external pull-ups, and nothing drives either line while the link is quiet. The side that pulls low first owns the transfer (the master). The other side (the slave) copies that low after a fixed propagation delay. While the transfer runs, falling edges on the slave side are ignored, so the slave's own low level cannot reverse the direction. When the master lets go, the slave pull-down is released and a short active pull-up pulse sharpens the rising edge. After that pulse the link is idle again, and the next falling edge on either side may start a new transfer.

The logic sees only the two line levels, after two-flop synchronizers, and a system clock. It drives a pull-down enable, an active pull-up enable and a master status flag for each side. Three identical lanes are built side by side: one for the main data line and two for auxiliary lines. Every lane level is a plain signal. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. A low enable forces every output of every lane inactive and returns each lane to idle.

The propagation delay (`DELAY_CYC`) and the pulse length (`PULSE_CYC`) are counted in clock cycles. The line toggle rate is limited to 1 MHz, so both times together must be much shorter than half of that period.

Top module: `lrep_array`

## Requirements
- R1: After reset, all pull-down, pull-up and master outputs are 0 on every lane.
- R2: Host side falls first while idle: the host master flag rises 3 cycles after the host line falls at the pins, and the card pull-down rises `DELAY_CYC`+3 cycles after that fall (counted in clock edges from the cycle the level changes at the input).
- R3: Card side falls first while idle: the mirror of R2, with the card master flag and the host pull-down.
- R4: While one side is master, lows on the slave side never set the slave's master flag and never enable the master side's pull-down.
- R5: When the master line returns high, the slave pull-down drops and the slave pull-up rises in the same cycle, 3 cycles after the rise at the pins. The pull-up stays high for exactly `PULSE_CYC` cycles.
- R6: After the pulse, both master flags are 0, and a falling edge on either side can start the next transfer.
- R7: If both sides fall in the same cycle, the host side becomes master.
- R8: If the master line returns high before the delay expires, the slave pull-down is never enabled and the lane returns to idle without a pull-up pulse.
- R9: On any side, the pull-down and the pull-up are never high in the same cycle.
- R10: While the enable is low, every output is 0 and each lane goes idle. A line that is already low when the enable rises does not start a transfer, and its later rise gives no pulse.
- R11: The lanes work independently: transfers in opposite directions on different lanes proceed at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Repeater enable; low forces all outputs off |
| host_lvl_i | input | N_LINES | Sensed host-side line levels (asynchronous) |
| card_lvl_i | input | N_LINES | Sensed card-side line levels (asynchronous) |
| host_pd_o | output | N_LINES | Host-side pull-down enable |
| host_pu_o | output | N_LINES | Host-side active pull-up enable |
| card_pd_o | output | N_LINES | Card-side pull-down enable |
| card_pu_o | output | N_LINES | Card-side active pull-up enable |
| host_mst_o | output | N_LINES | Host side is master of the current transfer |
| card_mst_o | output | N_LINES | Card side is master of the current transfer |

## Verification
The bench models the wired lines by combining its own drivers with the block's pull-downs. It pulls the card low while the host is already master. A design without the slave edge block would flip direction and drive both sides low at once. Both sides are made to fall in the same cycle, where a design without a fixed priority would start two masters. A host pulse shorter than the delay checks that a glitch is not copied to the card or followed by a stray pull-up pulse. The enable is also dropped in the middle of a transfer and raised again while a line is still held low. A design that kept its old edge history across the disabled time would then start a false transfer.

// File: rtl/lrep_pkg.sv
package lrep_pkg;

  typedef enum logic [2:0] {
    LR_IDLE    = 3'd0,
    LR_H_WAIT  = 3'd1,
    LR_H_HOLD  = 3'd2,
    LR_H_PULSE = 3'd3,
    LR_C_WAIT  = 3'd4,
    LR_C_HOLD  = 3'd5,
    LR_C_PULSE = 3'd6
  } lrep_state_t;

  function automatic int lrep_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lrep_sync.sv
module lrep_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage1;

  // lines rest high, so both stages come out of reset at 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '1;
      sync_o <= '1;
    end else begin
      stage1 <= async_i;
      sync_o <= stage1;
    end
  end

endmodule

// File: rtl/lrep_channel.sv
module lrep_channel
  import lrep_pkg::*;
#(
  parameter int DELAY_CYC = 4,
  parameter int PULSE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic host_lvl,
  input  logic card_lvl,
  output logic host_pd,
  output logic host_pu,
  output logic card_pd,
  output logic card_pu,
  output logic host_mst,
  output logic card_mst
);

  localparam int CMAX     = lrep_max(DELAY_CYC, PULSE_CYC);
  localparam int CW       = $clog2(CMAX + 1);
  localparam int DLY_LAST = DELAY_CYC - 1;
  localparam int PU_LAST  = PULSE_CYC - 1;

  lrep_state_t   st;
  logic [CW-1:0] cnt;
  logic          host_prev, card_prev;
  logic          host_fall, card_fall;

  assign host_fall = host_prev & ~host_lvl;
  assign card_fall = card_prev & ~card_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LR_IDLE;
      cnt       <= '0;
      host_prev <= 1'b1;
      card_prev <= 1'b1;
    end else begin
      host_prev <= host_lvl;
      card_prev <= card_lvl;
      if (!en) begin
        st  <= LR_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          LR_IDLE: begin
            cnt <= '0;
            if (host_fall)      st <= LR_H_WAIT;  // host wins a tie
            else if (card_fall) st <= LR_C_WAIT;
          end
          LR_H_WAIT: begin
            if (host_lvl) begin
              st  <= LR_IDLE;
              cnt <= '0;
            end else if (cnt == CW'(DLY_LAST)) begin
              st  <= LR_H_HOLD;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          LR_H_HOLD: begin
            if (host_lvl) begin
              st  <= LR_H_PULSE;
              cnt <= '0;
            end
          end
          LR_H_PULSE: begin
            if (cnt == CW'(PU_LAST)) begin
              st  <= LR_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          LR_C_WAIT: begin
            if (card_lvl) begin
              st  <= LR_IDLE;
              cnt <= '0;
            end else if (cnt == CW'(DLY_LAST)) begin
              st  <= LR_C_HOLD;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          LR_C_HOLD: begin
            if (card_lvl) begin
              st  <= LR_C_PULSE;
              cnt <= '0;
            end
          end
          LR_C_PULSE: begin
            if (cnt == CW'(PU_LAST)) begin
              st  <= LR_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            st  <= LR_IDLE;
            cnt <= '0;
          end
        endcase
      end
    end
  end

  always_comb begin
    card_pd  = en && (st == LR_H_HOLD);
    card_pu  = en && (st == LR_H_PULSE);
    host_pd  = en && (st == LR_C_HOLD);
    host_pu  = en && (st == LR_C_PULSE);
    host_mst = en && (st == LR_H_WAIT || st == LR_H_HOLD || st == LR_H_PULSE);
    card_mst = en && (st == LR_C_WAIT || st == LR_C_HOLD || st == LR_C_PULSE);
  end

  // R9: one side is never pulled both ways at once
  a_r9_host_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pd && host_pu));
  a_r9_card_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_pd && card_pu));

  // R4: direction is never shared
  a_r4_one_master: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_mst && card_mst));

  // R2 / R3: a slave is only pulled down on behalf of the opposite master
  a_r2_card_pd_owner: assert property (@(posedge clk) disable iff (!rst_n)
    card_pd |-> host_mst);
  a_r3_host_pd_owner: assert property (@(posedge clk) disable iff (!rst_n)
    host_pd |-> card_mst);

  // R5: a released slave pull-down hands over to the pull-up pulse
  a_r5_card_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(card_pd)) |-> card_pu);
  a_r5_host_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(host_pd)) |-> host_pu);

  // R10: a disabled cycle leaves no master behind
  a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(host_mst || card_mst));

endmodule

// File: rtl/lrep_array.sv
module lrep_array #(
  parameter int N_LINES   = 3,
  parameter int DELAY_CYC = 4,
  parameter int PULSE_CYC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [N_LINES-1:0] host_lvl_i,
  input  logic [N_LINES-1:0] card_lvl_i,
  output logic [N_LINES-1:0] host_pd_o,
  output logic [N_LINES-1:0] host_pu_o,
  output logic [N_LINES-1:0] card_pd_o,
  output logic [N_LINES-1:0] card_pu_o,
  output logic [N_LINES-1:0] host_mst_o,
  output logic [N_LINES-1:0] card_mst_o
);

  logic [N_LINES-1:0] host_s, card_s;

  lrep_sync #(.WIDTH(N_LINES)) u_host_sync (
    .clk(clk), .rst_n(rst_n), .async_i(host_lvl_i), .sync_o(host_s)
  );

  lrep_sync #(.WIDTH(N_LINES)) u_card_sync (
    .clk(clk), .rst_n(rst_n), .async_i(card_lvl_i), .sync_o(card_s)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_lane
    lrep_channel #(
      .DELAY_CYC(DELAY_CYC),
      .PULSE_CYC(PULSE_CYC)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .host_lvl(host_s[g]),
      .card_lvl(card_s[g]),
      .host_pd (host_pd_o[g]),
      .host_pu (host_pu_o[g]),
      .card_pd (card_pd_o[g]),
      .card_pu (card_pu_o[g]),
      .host_mst(host_mst_o[g]),
      .card_mst(card_mst_o[g])
    );
  end

endmodule

// File: tb/lrep_array_tb.sv
module lrep_array_tb;

  localparam int NL  = 3;
  localparam int DLY = 4;
  localparam int PU  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [NL-1:0] host_drv = '0, card_drv = '0;
  logic [NL-1:0] host_line, card_line;
  logic [NL-1:0] host_pd, host_pu, card_pd, card_pu, host_mst, card_mst;

  int cyc = 0;
  int nchk = 0;
  int nbad = 0;
  int overlap_err = 0;
  bit mon_busy = 1'b0;

  typedef struct {
    int lane;
    bit card_master;
    int pd_on;
    int pu_on;
    int pu_off;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // open-drain wiring: low if anyone pulls down
  assign host_line = ~(host_drv | host_pd);
  assign card_line = ~(card_drv | card_pd);

  lrep_array #(.N_LINES(NL), .DELAY_CYC(DLY), .PULSE_CYC(PU)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .host_lvl_i(host_line), .card_lvl_i(card_line),
    .host_pd_o(host_pd), .host_pu_o(host_pu),
    .card_pd_o(card_pd), .card_pu_o(card_pu),
    .host_mst_o(host_mst), .card_mst_o(card_mst)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R9 watcher
  always @(negedge clk)
    if (rst_n && (((host_pd & host_pu) | (card_pd & card_pu)) != '0)) overlap_err++;

  // driver: one transfer from the given side, expectation goes to the scoreboard
  task automatic xfer(input int lane, input bit from_card, input int low);
    exp_t e;
    @(negedge clk);
    if (from_card) card_drv[lane] = 1'b1; else host_drv[lane] = 1'b1;
    e.lane = lane; e.card_master = from_card;
    e.pd_on = cyc + DLY + 3;
    e.pu_on = cyc + low + 3;
    e.pu_off = cyc + low + 3 + PU;
    exp_q.push_back(e);
    repeat (low) @(negedge clk);
    if (from_card) card_drv[lane] = 1'b0; else host_drv[lane] = 1'b0;
    repeat (PU + 8) @(negedge clk);
  endtask

  // monitor: pops expectations and compares against the slave outputs
  initial begin
    forever begin
      exp_t e;
      int n;
      wait (exp_q.size() > 0);
      mon_busy = 1'b1;
      e = exp_q.pop_front();
      n = 0;
      @(negedge clk);
      while ((e.card_master ? host_pd[e.lane] : card_pd[e.lane]) !== 1'b1 && n < 200) begin
        @(negedge clk); n++;
      end
      chk(e.card_master ? "R3 slave pull-down timing" : "R2 slave pull-down timing", cyc, e.pd_on);
      chk("R2/R3 master flag", e.card_master ? card_mst[e.lane] : host_mst[e.lane], 1);
      n = 0;
      while ((e.card_master ? host_pu[e.lane] : card_pu[e.lane]) !== 1'b1 && n < 200) begin
        @(negedge clk); n++;
      end
      chk("R5 pull-up start", cyc, e.pu_on);
      chk("R5 pull-down released", e.card_master ? host_pd[e.lane] : card_pd[e.lane], 0);
      n = 0;
      while ((e.card_master ? host_pu[e.lane] : card_pu[e.lane]) !== 1'b0 && n < 200) begin
        @(negedge clk); n++;
      end
      chk("R5 pull-up end", cyc, e.pu_off);
      chk("R6 idle after pulse", {host_mst[e.lane], card_mst[e.lane]}, 0);
      mon_busy = 1'b0;
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reset outputs", {host_pd, host_pu, card_pd, card_pu, host_mst, card_mst}, 0);
    repeat (4) @(negedge clk);

    // R2, R5, R6: host-led transfers, then card-led right after (R3, R6)
    xfer(0, 1'b0, 12);
    xfer(0, 1'b1, 20);
    xfer(1, 1'b0, 9);
    xfer(2, 1'b1, 15);
    wait (exp_q.size() == 0 && !mon_busy);

    // R4: card pulled low externally while host is master
    @(negedge clk);
    host_drv[1] = 1'b1;
    repeat (DLY + 5) @(negedge clk);
    card_drv[1] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 slave stays slave", card_mst[1], 0);
    chk("R4 no reverse pull-down", host_pd[1], 0);
    chk("R4 host still master", host_mst[1], 1);
    card_drv[1] = 1'b0;
    repeat (3) @(negedge clk);
    host_drv[1] = 1'b0;
    repeat (PU + 8) @(negedge clk);
    chk("R6 lane 1 idle", {host_mst[1], card_mst[1]}, 0);

    // R7: both sides fall in the same cycle
    host_drv[0] = 1'b1; card_drv[0] = 1'b1;
    repeat (DLY + 3) @(negedge clk);
    chk("R7 host wins tie", {host_mst[0], card_mst[0]}, 2);
    chk("R7 card pulled down", card_pd[0], 1);
    chk("R7 host not pulled down", host_pd[0], 0);
    host_drv[0] = 1'b0; card_drv[0] = 1'b0;
    repeat (PU + 8) @(negedge clk);

    // R8: glitch shorter than the delay
    t0 = cyc;
    host_drv[2] = 1'b1;
    repeat (2) @(negedge clk);
    host_drv[2] = 1'b0;
    @(negedge clk);
    chk("R8 glitch took mastership", host_mst[2], 1);
    begin
      int seen = 0;
      while (cyc < t0 + 16) begin
        @(negedge clk);
        if (card_pd[2] || card_pu[2]) seen++;
      end
      chk("R8 no slave drive or pulse", seen, 0);
    end
    chk("R8 idle after glitch", host_mst[2], 0);

    // R10: enable dropped mid-transfer, raised with line still low
    host_drv[0] = 1'b1;
    repeat (DLY + 5) @(negedge clk);
    chk("R10 pre-check drive active", card_pd[0], 1);
    en = 1'b0;
    @(negedge clk);
    chk("R10 all outputs off", {host_pd, host_pu, card_pd, card_pu, host_mst, card_mst}, 0);
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 held low gives no transfer", host_mst[0], 0);
    host_drv[0] = 1'b0;
    begin
      int seen = 0;
      repeat (10) begin
        @(negedge clk);
        if (card_pu[0] || card_pd[0]) seen++;
      end
      chk("R10 no pulse after release", seen, 0);
    end

    // R11: opposite directions on two lanes at once
    host_drv[0] = 1'b1; card_drv[2] = 1'b1;
    repeat (DLY + 3) @(negedge clk);
    chk("R11 card pull-downs", card_pd, 3'b001);
    chk("R11 host pull-downs", host_pd, 3'b100);
    chk("R11 host masters", host_mst, 3'b001);
    chk("R11 card masters", card_mst, 3'b100);
    host_drv[0] = 1'b0; card_drv[2] = 1'b0;
    repeat (PU + 8) @(negedge clk);
    chk("R6 all lanes idle", {host_mst, card_mst}, 0);

    chk("R9 no pull-down/pull-up overlap", overlap_err, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule